// File: doc/BRIEF.md
# NRZI Bit-Stuffing Line Serializer

This block turns a byte stream into a single-wire line level for a serial packet link that uses inverted non-return-to-zero coding. A packet is started when a byte marked as start-of-packet is offered while the block is idle. The block then sends an eight-bit synchronisation pattern (value 0x80) and takes the payload bytes one at a time, each least significant bit first. After six consecutive one bits it inserts a zero bit. The resulting bit stream is NRZI-coded: a one keeps the line level and a zero flips it.

One bit leaves per pulse of the bit-clock enable `bit_en`. Between packets the line rests at logic 1, and the coding register restarts from 1 at every packet start. The one-counter sees the synchronisation bits, the payload and the inserted zeros as one continuous stream, so it carries across byte boundaries. One bit time after the final bit, including a trailing inserted zero, the block raises a single-clock end-of-packet pulse and returns to idle.

The control is one state machine. `IDLE` goes to `SYNC` on a start-of-packet byte. `SYNC` goes to `FETCH` after the eighth pattern bit. `FETCH` goes to `DATA` on a byte handshake. `DATA` goes to `FETCH` after bit 7 of a byte that is not the last, and to `TAIL` after bit 7 of the last byte. From `SYNC` or `DATA`, a bit that completes a run of six ones moves the machine to `STUFF`. `STUFF` sends the zero and resumes at the state the interrupted slot would have entered. `TAIL` waits one bit slot, pulses end-of-packet and goes to `IDLE`.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: Out of reset and whenever `busy` is low, `line_out` is 1, `in_ready` is 0 and `eop_pulse` is 0.
- R2: A packet starts only when `in_valid` and `in_sop` are both high in idle. Its first eight bit slots carry the pattern 0x80 least significant bit first, which from the resting level 1 gives the line levels 0,1,0,1,0,1,0,0.
- R3: Payload bytes follow the pattern in the order they are accepted, and each byte leaves bit 0 first and bit 7 last.
- R4: In each bit slot a 1 bit leaves `line_out` unchanged and a 0 bit inverts it. The coding register restarts from 1 at every packet start.
- R5: After any six consecutive 1 bits, a 0 bit is inserted before the next bit. That 0 bit inverts the line like any other zero.
- R6: The run-of-ones count clears on every 0 bit, including an inserted one. It counts the pattern bits and continues across byte boundaries, so a run can begin in one byte and end in the next.
- R7: `in_ready` is high only while the block waits for the next payload byte: never during a pattern, data or inserted-zero slot. Exactly one byte is taken per `in_valid` and `in_ready` handshake, and the byte marked with `in_last` ends the packet.
- R8: `line_out` changes only on a clock edge at which `bit_en` is high.
- R9: `eop_pulse` is high for exactly one clock, on the bit slot that follows the final bit (including a trailing inserted zero). In that same clock `busy` falls and `line_out` is back at 1.
- R10: While idle, `in_valid` without `in_sop` starts nothing, and `in_sop` on bytes offered after the start has no effect on the bit stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-clock pulse per bit slot |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_sop | input | 1 | Offered byte begins a packet |
| in_last | input | 1 | Offered byte is the packet's final byte |
| in_ready | output | 1 | Block takes the offered byte this clock |
| line_out | output | 1 | NRZI-coded line level |
| busy | output | 1 | Packet in progress |
| eop_pulse | output | 1 | One-clock end-of-packet marker |

## Verification
The bench builds the expected line waveform from its own model of pattern, LSB-first order, zero insertion and NRZI coding, and compares it slot by slot. Its vectors aim at a run of ones that crosses a byte boundary, two inserted zeros within one packet, and an inserted zero that falls on the final bit of a packet. A design that reset the one-counter at each byte would lose the cross-boundary zero and come out one slot short. A design that dropped the trailing zero, or pulsed end-of-packet too early, would show a wrong bit count or a wrong gap before the pulse. An inserted zero that failed to toggle would flip every later level. Bursts of `in_valid` with `in_sop` low while idle must leave the line quiet.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_SYNC  = 3'd1,
        TX_FETCH = 3'd2,
        TX_DATA  = 3'd3,
        TX_STUFF = 3'd4,
        TX_TAIL  = 3'd5
    } tx_state_e;

    function automatic logic is_bit_slot(input tx_state_e s);
        return (s == TX_SYNC) || (s == TX_DATA) || (s == TX_STUFF);
    endfunction

endpackage

// File: rtl/tx_bit_shifter.sv
module tx_bit_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic             bit_o,
    output logic             last_o
);
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

    logic [WIDTH-1:0] sh_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[0];
    assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/tx_run_tracker.sv
module tx_run_tracker #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  logic bit_i,
    output logic stuff_due_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] TRIGGER = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] ones_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ones_q <= '0;
        end else if (advance) begin
            ones_q <= bit_i ? ones_q + 1'b1 : '0;
        end
    end

    // the bit now in its slot closes a run: the next slot must carry a zero
    assign stuff_due_o = bit_i && (ones_q == TRIGGER);
endmodule

// File: rtl/tx_line_encoder.sv
module tx_line_encoder #(
    parameter logic REST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restore,
    input  logic advance,
    input  logic bit_i,
    output logic line_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restore) begin
            lvl_q <= REST_LEVEL;
        end else if (advance && !bit_i) begin
            lvl_q <= ~lvl_q;
        end
    end

    assign line_o = lvl_q;
endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
    import nrzi_tx_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          STUFF_RUN = 6,
    parameter logic [7:0]  SYNC_WORD = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_last,
    output logic              in_ready,
    output logic              line_out,
    output logic              busy,
    output logic              eop_pulse
);
    localparam logic [DATA_W-1:0] SYNC_EXT = DATA_W'(SYNC_WORD);

    tx_state_e state_q, state_d;
    tx_state_e resume_q, resume_d;
    tx_state_e after_bit;
    logic      last_q;
    logic      eop_q;

    logic start, take, emit, tx_bit;
    logic sh_load, sh_shift, sh_bit, sh_last;
    logic [DATA_W-1:0] sh_val;
    logic stuff_due, tail_done;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TX_IDLE;
            resume_q <= TX_IDLE;
            last_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            resume_q <= resume_d;
            if (take) last_q <= in_last;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        // where the current bit slot leads if no zero is inserted
        after_bit = state_q;
        if (sh_last) begin
            if (state_q == TX_SYNC)      after_bit = TX_FETCH;
            else if (state_q == TX_DATA) after_bit = last_q ? TX_TAIL : TX_FETCH;
        end

        state_d  = state_q;
        resume_d = resume_q;
        unique case (state_q)
            TX_IDLE: begin
                if (in_valid && in_sop) state_d = TX_SYNC;
            end
            TX_SYNC, TX_DATA: begin
                if (bit_en) begin
                    if (stuff_due) begin
                        state_d  = TX_STUFF;
                        resume_d = after_bit;
                    end else begin
                        state_d = after_bit;
                    end
                end
            end
            TX_STUFF: begin
                if (bit_en) state_d = resume_q;
            end
            TX_FETCH: begin
                if (in_valid) state_d = TX_DATA;
            end
            TX_TAIL: begin
                if (bit_en) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // ---------------- outputs and datapath controls ----------------
    always_comb begin
        start     = (state_q == TX_IDLE) && in_valid && in_sop;
        take      = (state_q == TX_FETCH) && in_valid;
        emit      = bit_en && is_bit_slot(state_q);
        tx_bit    = (state_q == TX_STUFF) ? 1'b0 : sh_bit;
        sh_load   = start || take;
        sh_val    = start ? SYNC_EXT : in_data;
        sh_shift  = emit && (state_q != TX_STUFF);
        tail_done = (state_q == TX_TAIL) && bit_en;
        in_ready  = (state_q == TX_FETCH);
        busy      = (state_q != TX_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eop_q <= 1'b0;
        else        eop_q <= tail_done;
    end
    assign eop_pulse = eop_q;

    // ---------------- datapath ----------------
    tx_bit_shifter #(.WIDTH(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .bit_o    (sh_bit),
        .last_o   (sh_last)
    );

    tx_run_tracker #(.RUN_LEN(STUFF_RUN)) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start),
        .advance     (emit),
        .bit_i       (tx_bit),
        .stuff_due_o (stuff_due)
    );

    tx_line_encoder #(.REST_LEVEL(1'b1)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .restore (start || tail_done),
        .advance (emit),
        .bit_i   (tx_bit),
        .line_o  (line_out)
    );
endmodule

// File: rtl/nrzi_stuff_tx_checker.sv
module nrzi_stuff_tx_checker #(
    parameter int RUN_MAX = 6
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic in_valid,
    input logic in_sop,
    input logic in_ready,
    input logic busy,
    input logic line_out,
    input logic eop_pulse
);
    logic       slot_q;
    logic       line_prev_q;
    logic [3:0] hold_run_q;
    logic       held;

    assign held = slot_q && (line_out == line_prev_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q      <= 1'b0;
            line_prev_q <= 1'b1;
            hold_run_q  <= '0;
        end else begin
            slot_q      <= bit_en && busy;
            line_prev_q <= line_out;
            if (slot_q) hold_run_q <= held ? hold_run_q + 1'b1 : '0;
        end
    end

    assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (line_out && !in_ready));

    assert_ready_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    assert_line_on_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_out));

    assert_run_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (hold_run_q < 4'(RUN_MAX)));

    assert_eop_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |=> !eop_pulse);

    assert_eop_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |-> (!busy && line_out));

    assert_start_needs_sop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid && in_sop));
endmodule

bind nrzi_stuff_tx nrzi_stuff_tx_checker #(.RUN_MAX(6)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_ready  (in_ready),
    .busy      (busy),
    .line_out  (line_out),
    .eop_pulse (eop_pulse)
);

// File: tb/nrzi_stuff_tx_bench.sv
module nrzi_stuff_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready, line_out, busy, eop_pulse;

    always #10 clk = ~clk;

    nrzi_stuff_tx u_nrzi_stuff_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
        .in_valid(in_valid), .in_sop(in_sop), .in_last(in_last),
        .in_ready(in_ready), .line_out(line_out), .busy(busy),
        .eop_pulse(eop_pulse)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // {length[3:0], bytes[31:0] (first byte in [7:0]), expected slot count[7:0]}
    localparam int NVEC = 6;
    localparam logic [43:0] VEC [NVEC] = '{
        {4'd1, 32'h0000_0000, 8'd16},  // no insertion
        {4'd1, 32'h0000_00FF, 8'd17},  // run starts in pattern's final 1
        {4'd2, 32'h0000_3F80, 8'd25},  // run crosses a byte boundary
        {4'd1, 32'h0000_00FC, 8'd17},  // inserted zero on the final bit
        {4'd2, 32'h0000_FFFF, 8'd26},  // two insertions in one packet
        {4'd3, 32'h0001_7EA5, 8'd33}   // mixed bytes
    };

    // ---------------- bit slot generator and line monitor ----------------
    logic cap [0:63];
    int   cap_n = 0;
    int   eop_cnt = 0;
    int   eop_at = -1;
    int   eop_gap = -1;
    logic eop_line = 1'b0;
    int   slots_since = 0;
    int   nonslot_chg = 0;
    logic prev_busy = 1'b0;
    logic prev_line = 1'b1;

    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            begin
                logic s_en;
                s_en = bit_en;
                if (s_en && prev_busy && busy) begin
                    if (cap_n < 64) cap[cap_n] = line_out;
                    cap_n++;
                    slots_since = 0;
                end else if (s_en) begin
                    slots_since++;
                end
                if (!s_en && rst_n && (line_out != prev_line)) nonslot_chg++;
                if (eop_pulse) begin
                    eop_cnt++;
                    eop_at   = cap_n;
                    eop_gap  = slots_since;
                    eop_line = line_out;
                end
                prev_busy = busy;
                prev_line = line_out;
                bit_en = (phase == 3);
                phase  = (phase + 1) % 4;
            end
        end
    end

    // ---------------- independent model ----------------
    logic exp_lvl [0:63];

    task automatic build_expected(input int len, input logic [31:0] bytes, output int n);
        logic raw [0:63];
        int   ones;
        logic lvl;
        logic [7:0] b;
        n = 0;
        ones = 0;
        for (int k = 0; k <= len; k++) begin
            b = (k == 0) ? 8'h80 : bytes[8*(k-1) +: 8];
            for (int i = 0; i < 8; i++) begin
                raw[n] = b[i]; n++;
                ones = b[i] ? ones + 1 : 0;
                if (ones == 6) begin raw[n] = 1'b0; n++; ones = 0; end
            end
        end
        lvl = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (!raw[i]) lvl = ~lvl;
            exp_lvl[i] = lvl;
        end
    endtask

    // ---------------- packet driver ----------------
    task automatic run_packet(input int len, input logic [31:0] bytes, input int exp_slots);
        int n_model, k, hs, t, bad, first_bad;
        build_expected(len, bytes, n_model);
        @(negedge clk);
        cap_n = 0; eop_cnt = 0; eop_at = -1; eop_gap = -1; nonslot_chg = 0;
        k = 0; hs = 0;
        in_data = bytes[7:0]; in_sop = 1'b1; in_last = (len == 1); in_valid = 1'b1;
        t = 0;
        while (k < len && t < 2000) begin
            @(negedge clk); t++;
            if (in_ready) begin
                hs++;
                @(posedge clk); #1;
                k++;
                if (k < len) begin
                    in_data = bytes[8*k +: 8];
                    in_last = (k == len - 1);
                end else begin
                    in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0;
                end
            end
        end
        t = 0;
        while (eop_cnt == 0 && t < 2000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);

        check(n_model == exp_slots, "R5 R6 model slot count", n_model, exp_slots);
        check(cap_n == exp_slots, "R5 R6 emitted slot count", cap_n, exp_slots);
        bad = 0; first_bad = -1;
        for (int i = 0; i < n_model && i < 64; i++)
            if (cap[i] !== exp_lvl[i]) begin bad++; if (first_bad < 0) first_bad = i; end
        check(bad == 0, "R2 R3 R4 waveform mismatches (first at slot shown in log)", bad, 0);
        if (bad != 0) $display("  first mismatching slot %0d", first_bad);
        check(hs == len, "R7 handshakes per packet", hs, len);
        check(eop_cnt == 1, "R9 end pulses", eop_cnt, 1);
        check(eop_at == exp_slots, "R9 pulse after final slot", eop_at, exp_slots);
        check(eop_gap == 1, "R9 slots between final bit and pulse", eop_gap, 1);
        check(eop_line == 1'b1, "R9 line at rest with pulse", int'(eop_line), 1);
        check(nonslot_chg == 0, "R8 line changes outside a slot", nonslot_chg, 0);
        check(!busy && line_out, "R1 idle after packet", int'({busy, line_out}), 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        check(line_out == 1'b1, "R1 line during reset", int'(line_out), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(line_out == 1'b1, "R1 line after reset", int'(line_out), 1);
        check(!busy && !in_ready && !eop_pulse, "R1 flags after reset",
              int'({busy, in_ready, eop_pulse}), 0);

        // R10: valid without start marker while idle starts nothing
        in_valid = 1'b1; in_sop = 1'b0; in_data = 8'h00;
        begin
            int saw_busy = 0;
            int saw_change = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (busy || in_ready) saw_busy++;
                if (line_out != 1'b1) saw_change++;
            end
            check(saw_busy == 0, "R10 no start without sop", saw_busy, 0);
            check(saw_change == 0, "R10 line quiet without sop", saw_change, 0);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        // vector table: sop held high on every byte (R10 mid-packet sop)
        for (int v = 0; v < NVEC; v++) begin
            run_packet(int'(VEC[v][43:40]), VEC[v][39:8], int'(VEC[v][7:0]));
            repeat (5) @(negedge clk);
        end

        // back-to-back: second packet restarts coding from the resting level (R4)
        run_packet(1, 32'h0000_0000, 16);
        run_packet(1, 32'h0000_0000, 16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule